// File: doc/BRIEF.md
# Guest-to-Hypervisor World Switch Sequencer

This block switches a processor core between guest execution and hypervisor execution. When it accepts an exit request in guest mode, it first records why the exit happened and where in the guest it happened. It then saves the guest's architectural registers to a save area in memory and fills the register file with the hypervisor's state from a host area. A resume request in hypervisor mode runs the same steps mirrored. The host registers go back to the host area, the guest registers are reloaded from the save area, and the recorded guest instruction address is fetched and presented as the restart point.

The block drives a register file through one combinational read port and one write port. It drives memory through a single word-addressed port that takes one request per cycle when ready is high and returns read data one cycle after the request is accepted. Save-area layout, from the save base upward: word 0 holds the cause, word 1 holds the guest instruction address, and words 2 to N+1 hold guest registers 0 to N-1. The host area holds host registers 0 to N-1 from the host base upward.

States: `ST_IDLE`, exit path `ST_LOG_CAUSE` → `ST_LOG_PC` → `ST_SAVE_GUEST` → `ST_LOAD_HOST` → `ST_EXIT_FIN` → `ST_IDLE`, resume path `ST_SAVE_HOST` → `ST_LOAD_GUEST` → `ST_FETCH_PC` → `ST_RESUME_FIN` → `ST_IDLE`. The block leaves a single-word state on an accepted handshake, and leaves a repeated state on the accepted handshake for index N-1. A finish state always lasts one cycle.

Top module: `world_switch_seq`

## Requirements
- R1: After reset, mode is 0 (guest), and busy, done, mem_req and rf_we are all 0.
- R2: An exit request is accepted only when idle in guest mode, and a resume request only when idle in hypervisor mode. Any other request leaves busy low and issues no memory request.
- R3: The first memory access of an exit is a write of the cause code, zero-extended to the data width, to address save_base.
- R4: The second access of an exit writes the guest instruction address captured at acceptance to save_base+1.
- R5: Next, the exit writes guest register i to save_base+2+i for i in ascending order from 0 to N-1.
- R6: The exit then reads host_base+i for ascending i. The returned word is written into register i on the cycle after the read is accepted.
- R7: A resume writes register i to host_base+i for ascending i. It then reads save_base+2+i into register i for ascending i. Its last step reads save_base+1 and drives that word on resume_addr.
- R8: busy is high from the cycle after acceptance through the final cycle of the sequence. Requests that arrive while busy are ignored.
- R9: done pulses for exactly one cycle, in the cycle after the finish state. In that same cycle mode takes its new value (1 after an exit, 0 after a resume). Mode changes at no other time.
- R10: With mem_ready always high, busy lasts 2N+3 cycles for an exit and 2N+2 cycles for a resume.
- R11: A cycle with mem_req high and mem_ready low holds the request (address, direction, data) unchanged and lengthens the sequence by exactly one cycle.
- R12: The register file is written only by read returns: N writes per exit, N writes per resume, and none while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_req | input | 1 | Request to leave guest mode |
| exit_cause | input | CAUSE_W | Reason code captured with the exit request |
| exit_addr | input | DATA_W | Faulting guest instruction address |
| resume_req | input | 1 | Request to return to guest mode |
| save_base | input | ADDR_W | Base word address of the guest save area |
| host_base | input | ADDR_W | Base word address of the host state area |
| rf_raddr | output | log2(N_REGS) | Register file read index |
| rf_rdata | input | DATA_W | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | log2(N_REGS) | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after acceptance |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| busy | output | 1 | A switch sequence is in progress |
| mode | output | 1 | 0 = guest, 1 = hypervisor |
| done | output | 1 | One-cycle pulse ending a sequence |
| resume_addr | output | DATA_W | Guest restart address fetched on resume |

## Verification
The bench sweeps four base-address and stall-pattern configurations through full exit/resume round trips. It checks the ordered access log word by word, so a design that swapped the cause and address slots, saved registers in the wrong order, or let host loads overtake the guest save would produce a misplaced log entry. Each busy window is measured against the stall count the bench observes. A sequencer that advanced during a stall would give a short window, and one that let a finish state linger would give a long one. Mid-sequence requests and requests in the wrong mode are also applied: a design that re-armed would either restart the count or leave busy high after the ignored request.

// File: rtl/wsw_pkg.sv
package wsw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOG_CAUSE,
        ST_LOG_PC,
        ST_SAVE_GUEST,
        ST_LOAD_HOST,
        ST_EXIT_FIN,
        ST_SAVE_HOST,
        ST_LOAD_GUEST,
        ST_FETCH_PC,
        ST_RESUME_FIN
    } wsw_state_e;

    // Save-area word offsets (cause first, address second, registers after)
    localparam int SLOT_CAUSE = 0;
    localparam int SLOT_ADDR  = 1;
    localparam int SLOT_REG0  = 2;

endpackage

// File: rtl/wsw_ctrl.sv
module wsw_ctrl
    import wsw_pkg::*;
#(
    parameter int N_REGS = 16,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exit_req,
    input  logic             resume_req,
    input  logic             mem_ready,
    output wsw_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             exit_go,
    output logic             mode,
    output logic             done
);

    wsw_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             mode_q, done_q;
    logic             resume_go, last, repeat_st;

    assign exit_go   = (state_q == ST_IDLE) && exit_req && !mode_q;
    assign resume_go = (state_q == ST_IDLE) && resume_req && mode_q;
    assign last      = (idx_q == IDX_W'(N_REGS - 1));
    assign repeat_st = (state_q == ST_SAVE_GUEST) || (state_q == ST_LOAD_HOST) ||
                       (state_q == ST_SAVE_HOST)  || (state_q == ST_LOAD_GUEST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (exit_go)        state_d = ST_LOG_CAUSE;
                else if (resume_go) state_d = ST_SAVE_HOST;
            end
            ST_LOG_CAUSE:  if (mem_ready)         state_d = ST_LOG_PC;
            ST_LOG_PC:     if (mem_ready)         state_d = ST_SAVE_GUEST;
            ST_SAVE_GUEST: if (mem_ready && last) state_d = ST_LOAD_HOST;
            ST_LOAD_HOST:  if (mem_ready && last) state_d = ST_EXIT_FIN;
            ST_EXIT_FIN:                          state_d = ST_IDLE;
            ST_SAVE_HOST:  if (mem_ready && last) state_d = ST_LOAD_GUEST;
            ST_LOAD_GUEST: if (mem_ready && last) state_d = ST_FETCH_PC;
            ST_FETCH_PC:   if (mem_ready)         state_d = ST_RESUME_FIN;
            ST_RESUME_FIN:                        state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Word index within a repeated state
    always_ff @(posedge clk) begin
        if (!rst_n)                    idx_q <= '0;
        else if (state_d != state_q)   idx_q <= '0;
        else if (repeat_st && mem_ready) idx_q <= idx_q + IDX_W'(1);
    end

    // Registered outputs: mode flips together with the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_EXIT_FIN) || (state_q == ST_RESUME_FIN);
            if (state_q == ST_EXIT_FIN)   mode_q <= 1'b1;
            if (state_q == ST_RESUME_FIN) mode_q <= 1'b0;
        end
    end

    assign state = state_q;
    assign idx   = idx_q;
    assign mode  = mode_q;
    assign done  = done_q;

endmodule

// File: rtl/wsw_port_mux.sv
module wsw_port_mux
    import wsw_pkg::*;
#(
    parameter int N_REGS  = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int CAUSE_W = 8,
    localparam int IDX_W  = $clog2(N_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wsw_state_e         state,
    input  logic [IDX_W-1:0]   idx,
    input  logic               exit_go,
    input  logic [CAUSE_W-1:0] exit_cause,
    input  logic [DATA_W-1:0]  exit_addr,
    input  logic [ADDR_W-1:0]  save_base,
    input  logic [ADDR_W-1:0]  host_base,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [IDX_W-1:0]   rf_raddr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               rd_is_pc
);

    logic [CAUSE_W-1:0] cause_q;
    logic [DATA_W-1:0]  gaddr_q;
    logic [ADDR_W-1:0]  reg_slot, host_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            gaddr_q <= '0;
        end else if (exit_go) begin
            cause_q <= exit_cause;
            gaddr_q <= exit_addr;
        end
    end

    assign reg_slot  = save_base + ADDR_W'(SLOT_REG0) + ADDR_W'(idx);
    assign host_slot = host_base + ADDR_W'(idx);
    assign rf_raddr  = idx;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rd_is_pc  = 1'b0;
        unique case (state)
            ST_LOG_CAUSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = save_base + ADDR_W'(SLOT_CAUSE);
                mem_wdata = DATA_W'(cause_q);
            end
            ST_LOG_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = save_base + ADDR_W'(SLOT_ADDR);
                mem_wdata = gaddr_q;
            end
            ST_SAVE_GUEST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = reg_slot;
                mem_wdata = rf_rdata;
            end
            ST_LOAD_HOST: begin
                mem_req   = 1'b1;
                mem_addr  = host_slot;
            end
            ST_SAVE_HOST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = host_slot;
                mem_wdata = rf_rdata;
            end
            ST_LOAD_GUEST: begin
                mem_req   = 1'b1;
                mem_addr  = reg_slot;
            end
            ST_FETCH_PC: begin
                mem_req   = 1'b1;
                mem_addr  = save_base + ADDR_W'(SLOT_ADDR);
                rd_is_pc  = 1'b1;
            end
            default: begin
                mem_req   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wsw_rd_return.sv
module wsw_rd_return #(
    parameter int N_REGS = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic              rd_is_pc,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] resume_addr
);

    logic              pend_q, to_pc_q;
    logic [IDX_W-1:0]  dst_q;
    logic [DATA_W-1:0] raddr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            to_pc_q <= 1'b0;
            dst_q   <= '0;
        end else begin
            pend_q  <= rd_fire;
            to_pc_q <= rd_fire && rd_is_pc;
            if (rd_fire) dst_q <= rd_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                raddr_q <= '0;
        else if (pend_q && to_pc_q) raddr_q <= mem_rdata;
    end

    assign rf_we       = pend_q && !to_pc_q;
    assign rf_waddr    = dst_q;
    assign rf_wdata    = mem_rdata;
    assign resume_addr = raddr_q;

endmodule

// File: rtl/world_switch_seq.sv
module world_switch_seq
    import wsw_pkg::*;
#(
    parameter int N_REGS  = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int CAUSE_W = 8,
    localparam int IDX_W  = $clog2(N_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exit_req,
    input  logic [CAUSE_W-1:0] exit_cause,
    input  logic [DATA_W-1:0]  exit_addr,
    input  logic               resume_req,
    input  logic [ADDR_W-1:0]  save_base,
    input  logic [ADDR_W-1:0]  host_base,
    output logic [IDX_W-1:0]   rf_raddr,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               rf_we,
    output logic [IDX_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               mode,
    output logic               done,
    output logic [DATA_W-1:0]  resume_addr
);

    wsw_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             exit_go, rd_is_pc, rd_fire;

    wsw_ctrl #(.N_REGS(N_REGS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .exit_req   (exit_req),
        .resume_req (resume_req),
        .mem_ready  (mem_ready),
        .state      (state),
        .idx        (idx),
        .exit_go    (exit_go),
        .mode       (mode),
        .done       (done)
    );

    wsw_port_mux #(
        .N_REGS (N_REGS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CAUSE_W(CAUSE_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .idx        (idx),
        .exit_go    (exit_go),
        .exit_cause (exit_cause),
        .exit_addr  (exit_addr),
        .save_base  (save_base),
        .host_base  (host_base),
        .rf_rdata   (rf_rdata),
        .rf_raddr   (rf_raddr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_is_pc   (rd_is_pc)
    );

    assign rd_fire = mem_req && !mem_we && mem_ready;

    wsw_rd_return #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire     (rd_fire),
        .rd_is_pc    (rd_is_pc),
        .rd_idx      (idx),
        .mem_rdata   (mem_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .resume_addr (resume_addr)
    );

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wsw_checker.sv
module wsw_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exit_req,
    input logic              resume_req,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              rf_we,
    input logic              busy,
    input logic              mode,
    input logic              done
);

    // R8: no memory traffic outside a sequence
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: a stalled request is held unchanged
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R9: mode moves only together with done
    a_r9_mode_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> done);

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows the end of a busy window
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R12: register writes only inside a sequence
    a_r12_rf_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy);

    // R2: exit in hypervisor mode is not accepted
    a_r2_exit_in_hyp: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode && exit_req && !resume_req) |=> !busy);

    // R2: resume in guest mode is not accepted
    a_r2_resume_in_guest: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode && resume_req && !exit_req) |=> !busy);

endmodule

bind world_switch_seq wsw_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exit_req   (exit_req),
    .resume_req (resume_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .rf_we      (rf_we),
    .busy       (busy),
    .mode       (mode),
    .done       (done)
);

// File: tb/world_switch_seq_test.sv
module world_switch_seq_test;

    localparam int N  = 16;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exit_req = 1'b0, resume_req = 1'b0;
    logic [CW-1:0] exit_cause = '0;
    logic [DW-1:0] exit_addr = '0;
    logic [AW-1:0] save_base = '0, host_base = '0;
    logic [IW-1:0] rf_raddr, rf_waddr;
    logic [DW-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata, resume_addr;
    logic          rf_we, mem_req, mem_we, mem_ready, busy, mode, done;
    logic [AW-1:0] mem_addr;

    always #10 clk = ~clk;

    world_switch_seq #(.N_REGS(N), .DATA_W(DW), .ADDR_W(AW), .CAUSE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .exit_cause(exit_cause),
        .exit_addr(exit_addr), .resume_req(resume_req), .save_base(save_base),
        .host_base(host_base), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .mode(mode), .done(done), .resume_addr(resume_addr)
    );

    // Bench-side register file and memory with preload ports
    logic [DW-1:0] rf [N];
    logic [DW-1:0] mem [256];
    logic          pre_rf_we = 1'b0, pre_mem_we = 1'b0;
    logic [IW-1:0] pre_rf_idx = '0;
    logic [7:0]    pre_mem_adr = '0;
    logic [DW-1:0] pre_data = '0;
    logic [DW-1:0] rdata_q = '0;
    int            cyc = 0, stall_cnt = 0, rfw_cnt = 0, log_n = 0;
    int            stall_mode = 0;
    logic [AW-1:0] log_addr [512];
    logic          log_we [512];
    logic [DW-1:0] log_data [512];

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = rdata_q;
    assign mem_ready = (stall_mode == 0) ? 1'b1 :
                       (stall_mode == 1) ? (cyc % 3 != 0) : (cyc % 5 >= 2);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            rfw_cnt <= rfw_cnt + 1;
        end
        if (pre_rf_we) rf[pre_rf_idx] <= pre_data;
        if (pre_mem_we) mem[pre_mem_adr] <= pre_data;
        if (mem_req && !mem_ready) stall_cnt <= stall_cnt + 1;
        if (mem_req && mem_ready) begin
            log_addr[log_n[8:0]] <= mem_addr;
            log_we[log_n[8:0]]   <= mem_we;
            log_data[log_n[8:0]] <= mem_we ? mem_wdata : mem[mem_addr[7:0]];
            log_n <= log_n + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        rdata_q <= mem[mem_addr[7:0]];
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gval(int t, int i);
        return 32'h1000_0000 * (t + 1) + i * 32'h0101 + 32'd7;
    endfunction
    function automatic logic [DW-1:0] hval(int t, int i);
        return 32'hC000_0000 ^ (t << 20) ^ (i * 32'h3131);
    endfunction

    task automatic load_rf(input int t, input int kind);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            pre_rf_we  = 1'b1;
            pre_rf_idx = IW'(i);
            pre_data   = (kind == 0) ? gval(t, i) : (hval(t, i) ^ 32'h5A5A_0000);
        end
        @(negedge clk);
        pre_rf_we = 1'b0;
    endtask

    task automatic load_host(input int t, input int base);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            pre_mem_we  = 1'b1;
            pre_mem_adr = 8'(base + i);
            pre_data    = hval(t, i);
        end
        @(negedge clk);
        pre_mem_we = 1'b0;
    endtask

    // Runs one sequence; returns busy length, stalls and rf writes seen
    task automatic run_seq(input bit is_exit, input bit poke, output int blen,
                           output int stalls, output int rfw);
        int s0, w0, guard;
        @(negedge clk);
        s0 = stall_cnt;
        w0 = rfw_cnt;
        if (is_exit) exit_req = 1'b1; else resume_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        resume_req = 1'b0;
        blen = 0;
        guard = 0;
        while (busy && guard < 1000) begin
            blen++;
            if (poke && blen == 5) begin exit_req = 1'b1; resume_req = 1'b1; end
            else begin exit_req = 1'b0; resume_req = 1'b0; end
            @(negedge clk);
            guard++;
        end
        exit_req = 1'b0;
        resume_req = 1'b0;
        if (guard >= 1000) check(1'b0, "R8 busy never fell", 32'(blen), 32'd0);
        stalls = s0;
        stalls = stall_cnt - s0;
        rfw = rfw_cnt - w0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8: watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int blen, stalls, rfw, lb, sb, hb;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(mode == 1'b0, "R1 mode", 32'(mode), 32'd0);
        check(!busy && !done, "R1 busy/done", {30'd0, busy, done}, 32'd0);
        check(!mem_req && !rf_we, "R1 mem_req/rf_we", {30'd0, mem_req, rf_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mode, "R1 after release", {30'd0, busy, mode}, 32'd0);

        for (int t = 0; t < 4; t++) begin
            sb = 8 + 40 * t;
            hb = 100 + 30 * t;
            save_base  = AW'(sb);
            host_base  = AW'(hb);
            stall_mode = (t == 0) ? 0 : ((t == 2) ? 2 : 1);
            exit_cause = (t == 3) ? 8'hFF : CW'(8'h10 + t * 8'h31);
            exit_addr  = 32'h0040_1000 + t * 32'h44;
            load_rf(t, 0);
            load_host(t, hb);

            // Exit sequence
            lb = log_n;
            run_seq(1'b1, t == 1, blen, stalls, rfw);
            check(blen == 2 * N + 3 + stalls, "R10/R11 exit length", 32'(blen),
                  32'(2 * N + 3 + stalls));
            check(done && mode, "R9 exit done+mode", {30'd0, done, mode}, 32'd3);
            check(rfw == N, "R12 exit rf writes", 32'(rfw), 32'(N));
            check(log_n - lb == 2 * N + 2, "R5 exit access count", 32'(log_n - lb),
                  32'(2 * N + 2));
            check(log_we[lb] && log_addr[lb] == AW'(sb) && log_data[lb] == DW'(exit_cause),
                  "R3 cause write", log_data[lb], DW'(exit_cause));
            check(log_we[lb+1] && log_addr[lb+1] == AW'(sb + 1) && log_data[lb+1] == exit_addr,
                  "R4 address write", log_data[lb+1], exit_addr);
            for (int i = 0; i < N; i++) begin
                check(log_we[lb+2+i] && log_addr[lb+2+i] == AW'(sb + 2 + i) &&
                      log_data[lb+2+i] == gval(t, i), "R5 guest save",
                      log_data[lb+2+i], gval(t, i));
                check(!log_we[lb+2+N+i] && log_addr[lb+2+N+i] == AW'(hb + i),
                      "R6 host load address", 32'(log_addr[lb+2+N+i]), 32'(hb + i));
                check(rf[i] == hval(t, i), "R6 host reg value", rf[i], hval(t, i));
            end
            @(negedge clk);
            check(!done && mode, "R9 done one cycle", {30'd0, done, mode}, 32'd1);

            // R2: exit ignored in hypervisor mode
            lb = log_n;
            exit_req = 1'b1;
            @(negedge clk);
            exit_req = 1'b0;
            check(!busy && !mem_req, "R2 exit ignored in hyp", {30'd0, busy, mem_req}, 32'd0);
            @(negedge clk);
            check(log_n == lb && mode, "R2 no traffic", 32'(log_n - lb), 32'd0);

            // Hypervisor changes its registers
            load_rf(t, 1);

            // Resume sequence
            lb = log_n;
            run_seq(1'b0, t == 2, blen, stalls, rfw);
            check(blen == 2 * N + 2 + stalls, "R10/R11 resume length", 32'(blen),
                  32'(2 * N + 2 + stalls));
            check(done && !mode, "R9 resume done+mode", {30'd0, done, mode}, 32'd2);
            check(rfw == N, "R12 resume rf writes", 32'(rfw), 32'(N));
            check(log_n - lb == 2 * N + 1, "R7 resume access count", 32'(log_n - lb),
                  32'(2 * N + 1));
            for (int i = 0; i < N; i++) begin
                check(log_we[lb+i] && log_addr[lb+i] == AW'(hb + i) &&
                      log_data[lb+i] == (hval(t, i) ^ 32'h5A5A_0000), "R7 host save",
                      log_data[lb+i], hval(t, i) ^ 32'h5A5A_0000);
                check(!log_we[lb+N+i] && log_addr[lb+N+i] == AW'(sb + 2 + i),
                      "R7 guest restore address", 32'(log_addr[lb+N+i]), 32'(sb + 2 + i));
                check(rf[i] == gval(t, i), "R7 guest reg value", rf[i], gval(t, i));
            end
            check(!log_we[lb+2*N] && log_addr[lb+2*N] == AW'(sb + 1),
                  "R7 address fetch", 32'(log_addr[lb+2*N]), 32'(sb + 1));
            check(resume_addr == exit_addr, "R7 resume_addr", resume_addr, exit_addr);
            @(negedge clk);
            check(!done, "R9 resume done one cycle", 32'(done), 32'd0);

            // R2: resume ignored in guest mode
            lb = log_n;
            resume_req = 1'b1;
            @(negedge clk);
            resume_req = 1'b0;
            check(!busy && !mem_req, "R2 resume ignored in guest", {30'd0, busy, mem_req}, 32'd0);
            @(negedge clk);
            check(log_n == lb && !mode && !rf_we, "R2/R12 idle quiet", 32'(log_n - lb), 32'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule